// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and the next memory level. Each processor store is queued with its address and data, so the processor does not wait for the slow memory write. The queue has four entries by default, because stores tend to arrive in bursts. Queued writes go to memory one at a time, oldest first, over a request/acknowledge port. An entry leaves the queue only when memory acknowledges its write.

Read misses from the cache take priority over buffered writes at the memory port, since the processor is waiting for them. A read is first compared with every live entry. On a match it is answered in the same cycle from the youngest matching entry and never reaches memory. A read with no match is held until the port is free and then sent to memory ahead of all remaining writes. This removes the read-after-write hazard without draining the queue first.

The port is controlled by a four-state machine:
- PORT_IDLE: no request is on the port.
- PORT_WRITE: the head entry is presented as a write.
- PORT_WRITE_RDWAIT: a write is in flight and a read miss is waiting for it.
- PORT_READ: the pending read miss is presented.

Transitions:
- From PORT_IDLE, a new read miss goes to PORT_READ. Otherwise, if there is queued work (or a store arriving), the machine goes to PORT_WRITE.
- In PORT_WRITE, a read miss that arrives without an acknowledge moves to PORT_WRITE_RDWAIT. On an acknowledge the machine goes to PORT_READ if a new miss arrives in that cycle; otherwise it stays in PORT_WRITE while entries remain, and returns to PORT_IDLE when none do.
- PORT_WRITE_RDWAIT moves to PORT_READ on the acknowledge.
- PORT_READ, on its acknowledge, goes to PORT_WRITE if entries remain and to PORT_IDLE if not.

Top module: `wbuf_top`

## Requirements
- R1: While and after reset, the queue is empty: `st_stall`, `mem_req` and `rd_done` are all 0.
- R2: A store is taken when `st_valid` is high and `st_stall` is low. `st_stall` is high exactly when DEPTH (default 4) entries are held, and it stays high until a write acknowledge frees an entry.
- R3: Writes reach memory strictly in acceptance order. Each appears with `mem_we`=1 and the entry's address and data. An entry is removed only in the cycle its `mem_ack` is seen, and no write is presented while the queue is empty.
- R4: A read that matches no entry is sent as `mem_req` with `mem_we`=0 and `mem_addr`=`rd_addr`. `rd_done` is asserted with `rd_data`=`mem_rdata` in the cycle of its `mem_ack`.
- R5: A read miss issued while the port is idle goes out before any queued write. A read miss issued during an in-flight write is presented directly after that write's acknowledge, ahead of every other queued write.
- R6: A read whose address matches a live entry asserts `rd_done` in the same cycle it is raised and issues no memory read. It returns the data of the youngest matching entry.
- R7: A store accepted in the same cycle a read is raised is ordered after that read. It is not forwarded to that read.
- R8: Stores are never merged. Every accepted store, including repeats to one address, produces its own memory write.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor presents a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Queue full; the store must be held |
| rd_req | input | 1 | Read miss request, held until `rd_done` |
| rd_addr | input | AW | Read miss address |
| rd_done | output | 1 | Read result valid this cycle |
| rd_data | output | DW | Read result |
| mem_req | output | 1 | Memory port request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | DW | Read data, valid with `mem_ack` on a read |

## Verification
The bench keeps the queue full under slow memory, then issues a read miss. A design that drained all writes before the read would show several write acknowledges before `rd_done`. Reads after two stores to one address check the youngest-match rule; an oldest-first search would return the stale value. A store raised in the same cycle as a read to that address targets the forwarding order; wrong forwarding would hand the read the newer data, and a lost or merged store would leave the final memory contents or the write count off against a flat reference memory.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [1:0] {
        PORT_IDLE         = 2'd0,
        PORT_WRITE        = 2'd1,
        PORT_WRITE_RDWAIT = 2'd2,
        PORT_READ         = 2'd3
    } port_state_e;

endpackage

// File: rtl/wbuf_fifo.sv
// Circular store queue: entries are written at the tail and retired at the head.
module wbuf_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [PTR_W-1:0] head_ptr,
    output logic [CNT_W-1:0] occ,
    output logic             full,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    output logic [AW-1:0]    ent_addr [DEPTH],
    output logic [DW-1:0]    ent_data [DEPTH]
);

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Payload storage carries no reset; liveness comes from cnt.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_ptr  = rd_ptr;
    assign occ       = cnt;
    assign full      = (cnt == CNT_W'(DEPTH));
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign ent_addr[g] = addr_q[g];
        assign ent_data[g] = data_q[g];
    end

endmodule

// File: rtl/wbuf_match.sv
// Associative search of all live entries; the youngest match supplies the data.
module wbuf_match #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head_ptr,
    input  logic [CNT_W-1:0] occ,
    input  logic [AW-1:0]    ent_addr [DEPTH],
    input  logic [DW-1:0]    ent_data [DEPTH],
    input  logic [AW-1:0]    look_addr,
    output logic             hit,
    output logic [DW-1:0]    hit_data
);

    logic [PTR_W-1:0] slot_age [DEPTH];
    logic [DEPTH-1:0] slot_eq;

    // Age 0 is the oldest entry (the head); larger age means a younger store.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            int a;
            a = g - int'(head_ptr);
            if (a < 0) a = a + DEPTH;
            slot_age[g] = PTR_W'(a);
            slot_eq[g]  = (a < int'(occ)) && (ent_addr[g] == look_addr);
        end
    end

    always_comb begin
        logic [PTR_W-1:0] best_age;
        hit      = 1'b0;
        hit_data = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_eq[i] && (!hit || slot_age[i] > best_age)) begin
                hit      = 1'b1;
                best_age = slot_age[i];
                hit_data = ent_data[i];
            end
        end
    end

endmodule

// File: rtl/wbuf_port_fsm.sv
// Memory port arbiter: read misses are placed ahead of queued writes.
module wbuf_port_fsm
    import wbuf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_new,
    input  logic          rd_hit,
    input  logic [DW-1:0] rd_hit_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          push,
    input  logic          occ_nz,
    input  logic          occ_gt1,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          pop,
    output logic          rd_done,
    output logic [DW-1:0] rd_data,
    output logic          rd_busy,
    output port_state_e   state
);

    port_state_e   state_q;
    port_state_e   state_d;
    logic [AW-1:0] miss_addr_q;
    logic          miss_new;
    logic          work_if_pop;
    logic          work_if_keep;

    assign miss_new     = rd_new && !rd_hit;
    assign work_if_pop  = occ_gt1 || push;
    assign work_if_keep = occ_nz || push;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // Address of the read miss waiting for, or using, the port
    always_ff @(posedge clk) begin
        if (!rst_n)        miss_addr_q <= '0;
        else if (miss_new) miss_addr_q <= rd_addr;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: begin
                if (miss_new)          state_d = PORT_READ;
                else if (work_if_keep) state_d = PORT_WRITE;
            end
            PORT_WRITE: begin
                if (mem_ack) begin
                    if (miss_new)         state_d = PORT_READ;
                    else if (work_if_pop) state_d = PORT_WRITE;
                    else                  state_d = PORT_IDLE;
                end else if (miss_new) begin
                    state_d = PORT_WRITE_RDWAIT;
                end
            end
            PORT_WRITE_RDWAIT: begin
                if (mem_ack) state_d = PORT_READ;
            end
            PORT_READ: begin
                if (mem_ack) state_d = work_if_keep ? PORT_WRITE : PORT_IDLE;
            end
            default: state_d = PORT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = head_addr;
        mem_wdata = head_data;
        pop       = 1'b0;
        rd_busy   = 1'b0;
        rd_done   = rd_new && rd_hit;
        rd_data   = rd_hit_data;
        unique case (state_q)
            PORT_IDLE: begin
            end
            PORT_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                pop     = mem_ack;
            end
            PORT_WRITE_RDWAIT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                pop     = mem_ack;
                rd_busy = 1'b1;
            end
            PORT_READ: begin
                mem_req   = 1'b1;
                mem_addr  = miss_addr_q;
                mem_wdata = '0;
                rd_busy   = 1'b1;
                rd_done   = mem_ack;
                rd_data   = mem_rdata;
            end
            default: begin
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_stall,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_done,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push;
    logic             pop;
    logic             full;
    logic [PTR_W-1:0] head_ptr;
    logic [CNT_W-1:0] occ;
    logic [AW-1:0]    head_addr;
    logic [DW-1:0]    head_data;
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic             rd_hit;
    logic [DW-1:0]    rd_hit_data;
    logic             rd_busy;
    logic             rd_new;
    port_state_e      port_state;

    assign push     = st_valid && !full;
    assign st_stall = full;
    assign rd_new   = rd_req && !rd_busy;

    wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .head_ptr  (head_ptr),
        .occ       (occ),
        .full      (full),
        .head_addr (head_addr),
        .head_data (head_data),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
        .head_ptr  (head_ptr),
        .occ       (occ),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .look_addr (rd_addr),
        .hit       (rd_hit),
        .hit_data  (rd_hit_data)
    );

    wbuf_port_fsm #(.AW(AW), .DW(DW)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_new      (rd_new),
        .rd_hit      (rd_hit),
        .rd_hit_data (rd_hit_data),
        .rd_addr     (rd_addr),
        .push        (push),
        .occ_nz      (occ != '0),
        .occ_gt1     (occ > CNT_W'(1)),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pop         (pop),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .rd_busy     (rd_busy),
        .state       (port_state)
    );

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker
    import wbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             st_stall,
    input logic             rd_req,
    input logic             rd_done,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_wdata,
    input logic             mem_ack,
    input logic [CNT_W-1:0] occ,
    input port_state_e      port_state
);

    logic wr_ack;
    assign wr_ack = mem_req && mem_we && mem_ack;

    // R2: a full queue stays full until a write acknowledge frees a slot
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall && !wr_ack |=> st_stall);

    // R2: an accepted store without a retirement adds exactly one entry
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_stall && !wr_ack |=> occ == CNT_W'($past(occ) + CNT_W'(1)));

    // R3: no write is presented from an empty queue
    a_r3_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
        occ == '0 |-> !(mem_req && mem_we));

    // R4: a read acknowledge completes the read in the same cycle
    a_r4_done_on_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |-> rd_done);

    // R5: a waiting read miss takes the port right after the write in flight
    a_r5_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
        port_state == PORT_WRITE_RDWAIT && mem_ack |=> mem_req && !mem_we);

    // R6: a completion only answers a raised read
    a_r6_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> rd_req);

    // R9: the request stays put until acknowledged
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

endmodule

bind wbuf_top wbuf_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_stall   (st_stall),
    .rd_req     (rd_req),
    .rd_done    (rd_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .occ        (occ),
    .port_state (port_state)
);

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
module sim_wbuf_top;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic          st_stall;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_done;
    logic [DW-1:0] rd_data;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    always #2 clk = ~clk;   // 250 MHz

    wbuf_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference models ----------------
    typedef struct packed { logic [31:0] a; logic [31:0] d; } ent_t;
    ent_t        exp_q[$];                      // expected queue contents, oldest first
    logic [31:0] prog_mem [logic [31:0]];       // memory as seen in program order
    logic [31:0] low_mem  [logic [31:0]];       // lower-level memory contents

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] prog_rd(input logic [31:0] a);
        return prog_mem.exists(a) ? prog_mem[a] : init_val(a);
    endfunction

    int mem_lat     = 1;
    int wait_cnt    = 0;
    bit pop_pend    = 0;
    int wr_acks     = 0;
    int rd_acks     = 0;
    int stores_done = 0;

    // Memory responder and per-cycle queue-state comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
            pop_pend = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            if (pop_pend) begin
                void'(exp_q.pop_front());
                pop_pend = 0;
            end
        end else if (mem_req) begin
            if (wait_cnt >= mem_lat) begin
                wait_cnt = 0;
                mem_ack  = 1'b1;
                if (mem_we) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3", "write presented with empty model", mem_addr, 32'h0);
                    end else begin
                        chk(mem_addr == exp_q[0].a, "R3", "drain order address", mem_addr, exp_q[0].a);
                        chk(mem_wdata == exp_q[0].d, "R3", "drain order data", mem_wdata, exp_q[0].d);
                    end
                    low_mem[mem_addr] = mem_wdata;
                    pop_pend = 1;
                    wr_acks++;
                end else begin
                    mem_rdata = low_mem.exists(mem_addr) ? low_mem[mem_addr] : init_val(mem_addr);
                    rd_acks++;
                end
            end else begin
                wait_cnt++;
            end
        end
        if (rst_n)
            chk(st_stall == (exp_q.size() == DEPTH), "R2", "stall vs occupancy",
                32'(st_stall), 32'(exp_q.size() == DEPTH));
    end

    // ---------------- processor side ----------------
    task automatic op(input bit do_st, input logic [31:0] sa, input logic [31:0] sd,
                      input bit do_rd, input logic [31:0] ra);
        bit          st_pend = do_st;
        bit          rd_pend = do_rd;
        bit          first   = 1;
        bit          exp_hit = 0;
        bit          saw_hit = 0;
        bit          req_at_issue = 0;
        logic [31:0] exp_rd = '0;
        int          wr0 = 0;
        int          rd0 = 0;
        @(posedge clk); #1;
        st_valid = do_st; st_addr = sa; st_data = sd;
        rd_req   = do_rd; rd_addr = ra;
        while (st_pend || rd_pend) begin
            @(negedge clk); #0.5;
            if (rd_pend) begin
                if (first) begin
                    exp_rd  = prog_rd(ra);      // R7: read precedes a same-cycle store
                    exp_hit = 0;
                    foreach (exp_q[i]) if (exp_q[i].a == ra) exp_hit = 1;
                    wr0 = wr_acks;
                    rd0 = rd_acks;
                    req_at_issue = mem_req;
                    chk(rd_done == exp_hit, "R6", "completion in issue cycle", 32'(rd_done), 32'(exp_hit));
                end
                if (rd_done) begin
                    chk(rd_data == exp_rd, exp_hit ? "R6" : "R4", "read data", rd_data, exp_rd);
                    if (exp_hit) begin
                        saw_hit = 1;
                        chk(rd_acks == rd0, "R6", "memory reads during hit", 32'(rd_acks), 32'(rd0));
                    end else begin
                        chk((wr_acks - wr0) <= (req_at_issue ? 1 : 0), "R5",
                            "writes completed ahead of read miss", 32'(wr_acks - wr0),
                            32'(req_at_issue ? 1 : 0));
                    end
                    rd_pend = 0;
                end
            end
            if (st_pend && !st_stall) begin
                exp_q.push_back('{a: sa, d: sd});
                prog_mem[sa] = sd;
                stores_done++;
                st_pend = 0;
            end
            first = 0;
            @(posedge clk); #1;
            if (!st_pend) st_valid = 1'b0;
            if (!rd_pend) rd_req   = 1'b0;
        end
        if (saw_hit) begin
            @(negedge clk); #0.5;
            chk(!(mem_req && !mem_we), "R6", "no read request after hit",
                32'(mem_req && !mem_we), 32'h0);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #0.5;
            if (exp_q.size() == 0 && !mem_req && !mem_ack) break;
        end
    endtask

    logic [31:0] lf = 32'hACE1_1234;
    function automatic logic [31:0] lf_next(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        st_valid = 0; st_addr = '0; st_data = '0;
        rd_req = 0; rd_addr = '0;
        mem_ack = 0; mem_rdata = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #0.5;
        chk(!st_stall && !mem_req && !rd_done, "R1", "outputs during reset",
            {29'h0, st_stall, mem_req, rd_done}, 32'h0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #0.5;
        chk(!st_stall && !mem_req && !rd_done, "R1", "outputs after reset",
            {29'h0, st_stall, mem_req, rd_done}, 32'h0);

        // R2/R3: burst of five stores against slow memory fills the queue
        mem_lat = 8;
        for (int i = 0; i < 5; i++) op(1, 32'h200 + 32'(i * 4), 32'hD000 + 32'(i), 0, '0);
        drain();

        // R6/R8: repeated stores to one address, read takes the youngest
        mem_lat = 10;
        op(1, 32'h300, 32'h1111, 0, '0);
        op(1, 32'h300, 32'h2222, 0, '0);
        op(1, 32'h304, 32'h3333, 0, '0);
        op(0, '0, '0, 1, 32'h300);
        op(0, '0, '0, 1, 32'h304);
        // R5: miss while a write is in flight and others queue behind it
        op(0, '0, '0, 1, 32'h400);
        drain();

        // R5: miss against a full queue
        mem_lat = 4;
        for (int i = 0; i < 4; i++) op(1, 32'h500 + 32'(i * 4), 32'hE000 + 32'(i), 0, '0);
        op(0, '0, '0, 1, 32'h600);
        drain();

        // R5: miss raised while the port is idle with entries about to drain
        mem_lat = 6;
        op(1, 32'h640, 32'h0BAD, 1, 32'h644);
        drain();

        // R7: same-cycle store and read to a buffered address
        mem_lat = 12;
        op(1, 32'h700, 32'hAAAA, 0, '0);
        op(1, 32'h700, 32'hBBBB, 1, 32'h700);
        op(0, '0, '0, 1, 32'h700);
        // R7: same-cycle store and read miss
        op(1, 32'h704, 32'hCCCC, 1, 32'h704);
        drain();

        // Mixed traffic over a small address set
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            lf = lf_next(lf);
            mem_lat = int'(lf[10:8] % 3'd5);
            a = 32'h800 + {27'h0, lf[4:2], 2'b00};
            unique case (lf[1:0])
                2'd0, 2'd1: op(1, a, lf ^ 32'h1357_9BDF, 0, '0);
                2'd2:       op(0, '0, '0, 1, a);
                default:    op(1, a, lf, 1, 32'h800 + {27'h0, lf[7:5], 2'b00});
            endcase
        end
        drain();

        // R8: one memory write per accepted store; final memory image matches
        chk(wr_acks == stores_done, "R8", "memory writes vs stores", 32'(wr_acks), 32'(stores_done));
        foreach (prog_mem[a]) begin
            chk(low_mem.exists(a) && low_mem[a] == prog_mem[a], "R3", "final memory word",
                low_mem.exists(a) ? low_mem[a] : 32'hFFFF_FFFF, prog_mem[a]);
        end
        finish_run();
    end

endmodule